// File: doc/BRIEF.md
# Modified Miller Frame Encoder

This block drives the reader-to-card modulation of a Type A proximity link. It runs on the carrier clock. It turns a frame of transmit bits into a single control line. While that line is high the carrier is switched off for a short pause. Each bit cell lasts 128 carrier cycles. A cell holds one of three symbols: a pause in its first half (Z), a pause in its second half (X), or no pause at all (Y). The symbol chosen for a logic 0 depends on the bit sent just before it.

A transfer starts with a one-cycle start strobe. With the strobe the user supplies:

- a frame kind: short, standard or split;
- a data bit count.

The block then reads the frame bytes from a source that it addresses itself. It sends each byte least significant bit first. In standard and split frames it adds an odd parity bit where a byte ends. It frames the bits with a start-of-frame cell and a two-cell end-of-frame, and it pulses a done flag once the last cell has finished. In split frames, the last byte of the reader's half may be cut at any bit. A cut last byte carries no parity bit.

Top module: `mm_frame_encoder`

## Requirements
- R1: One bit cell lasts CELL_CYCLES carrier cycles (default 128). Consecutive cells follow each other with no gap.
- R2: With the default polarity, pause_o is 1 during a pause.
  - A Z cell pauses for PAUSE_CYCLES cycles (default 32) from cycle 0 of the cell.
  - An X cell pauses for PAUSE_CYCLES cycles from cycle CELL_CYCLES/2 of the cell.
  - A Y cell has no pause.
- R3: A logic 1 is sent as X. A logic 0 is sent as Z when the symbol before it was a logic 0 or the start-of-frame cell, and as Y otherwise. A leading run of zeros is therefore all Z.
- R4: A start strobe taken while idle makes the start-of-frame Z cell begin in the next cycle.
- R5: Every frame ends with a logic 0, coded as in R3, followed by one Y cell.
- R6: Data bit k is bit position k mod 8 of src_byte_i while src_idx_o equals k/8. The source must hold its value for the whole cell.
- R7: kind_i = 0 (short) sends exactly 7 data bits and no parity bit, whatever bit_count_i holds.
- R8: kind_i = 1 (standard) inserts an odd parity bit after every 8th data bit. It also inserts one after a final partial byte, computed over that byte's bits. Odd parity means the data bits and the parity bit together hold an odd number of ones.
- R9: kind_i = 2 or 3 (split) inserts an odd parity bit after each complete byte. No parity bit follows a final partial byte.
- R10: While idle, pause_o holds the no-pause level. done_o is high for exactly one cycle, the cycle after the last end-of-frame cell.
- R11: A start strobe that arrives while a frame is in progress is ignored. It does not change the frame being sent.
- R12: In standard and split frames, bit_count_i = 0 sends only the start-of-frame cell and the end-of-frame cells (Z, Z, Y).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to start a frame |
| kind_i | input | 2 | Frame kind: 0 short, 1 standard, 2 or 3 split |
| bit_count_i | input | CNT_W (12) | Number of data bits, parity not included |
| src_byte_i | input | 8 | Source byte at index src_idx_o |
| src_idx_o | output | CNT_W-3 (9) | Byte index of the data bit being sent |
| pause_o | output | 1 | Modulation control; default high means pause |
| done_o | output | 1 | One-cycle pulse after the frame ends |

## Verification
The start-of-frame cell begins in the cycle right after the edge that captures the strobe, and every later cell begins exactly 128 cycles after the one before it. The bench therefore reads pause_o on falling edges at three offsets into each cell: cycle 0, cycle PAUSE_CYCLES and cycle 64. From these samples it rebuilds the symbol of the cell and checks that no pause lasts longer than PAUSE_CYCLES. done_o is due one cycle after the final cell. The bench samples it on the falling edge that follows the last cell, and checks that it is low again one cycle later. A strobe injected in the middle of a frame is checked by comparing that frame against the model's symbol list, which is built from the original request.

// File: rtl/mm_enc_pkg.sv
package mm_enc_pkg;

   typedef enum logic [1:0] {
      KIND_SHORT    = 2'd0,
      KIND_STANDARD = 2'd1,
      KIND_SPLIT    = 2'd2
   } frame_kind_e;

   typedef enum logic [1:0] {
      SYM_Y = 2'd0,
      SYM_X = 2'd1,
      SYM_Z = 2'd2
   } cell_sym_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_SOF  = 3'd1,
      PH_DATA = 3'd2,
      PH_PAR  = 3'd3,
      PH_EOF0 = 3'd4,
      PH_EOFY = 3'd5
   } phase_e;

   // Logic value to symbol, given whether the previous symbol was a zero (or SOF)
   function automatic cell_sym_e code_bit(input logic b, input logic prev_zero);
      if (b)
         return SYM_X;
      else if (prev_zero)
         return SYM_Z;
      else
         return SYM_Y;
   endfunction

endpackage

// File: rtl/mm_cell_timer.sv
module mm_cell_timer #(
   parameter int CELL_CYCLES = 128,
   localparam int TW = $clog2(CELL_CYCLES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   output logic [TW-1:0] cnt_o,
   output logic          cell_end_o
);

   localparam logic [TW-1:0] LAST = TW'(CELL_CYCLES - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o      = cnt_q;
   assign cell_end_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/mm_bit_sequencer.sv
module mm_bit_sequencer
   import mm_enc_pkg::*;
#(
   parameter int CNT_W = 12,
   localparam int IDX_W = CNT_W - 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       kind_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [7:0]       byte_i,
   input  logic             cell_end_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] byte_idx_o,
   output cell_sym_e        sym_o
);

   localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(7);

   phase_e           phase_q;
   logic [CNT_W-1:0] bit_idx_q;
   logic [CNT_W-1:0] total_q;
   frame_kind_e      kind_q;
   logic             par_q;
   logic             prev_zero_q;
   logic             done_q;

   logic             cur_bit;
   logic             lbit;
   logic             last_bit;
   logic             byte_full;
   logic             want_par;
   logic [CNT_W-1:0] idx_next;

   assign cur_bit   = byte_i[bit_idx_q[2:0]];
   assign idx_next  = bit_idx_q + 1'b1;
   assign last_bit  = (idx_next == total_q);
   assign byte_full = (bit_idx_q[2:0] == 3'd7);
   assign want_par  = (kind_q != KIND_SHORT) &&
                      (byte_full || (last_bit && kind_q == KIND_STANDARD));

   always_comb begin
      unique case (phase_q)
         PH_DATA: lbit = cur_bit;
         PH_PAR:  lbit = par_q;
         default: lbit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (phase_q)
         PH_SOF:                   sym_o = SYM_Z;
         PH_DATA, PH_PAR, PH_EOF0: sym_o = code_bit(lbit, prev_zero_q);
         default:                  sym_o = SYM_Y;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         bit_idx_q   <= '0;
         total_q     <= '0;
         kind_q      <= KIND_SHORT;
         par_q       <= 1'b1;
         prev_zero_q <= 1'b1;
         done_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (start_i) begin
               phase_q     <= PH_SOF;
               bit_idx_q   <= '0;
               kind_q      <= frame_kind_e'(kind_i);
               total_q     <= (kind_i == 2'd0) ? SHORT_LEN : count_i;
               par_q       <= 1'b1;
               prev_zero_q <= 1'b1;
            end
         end else if (cell_end_i) begin
            unique case (phase_q)
               PH_SOF: begin
                  prev_zero_q <= 1'b1;
                  phase_q     <= (total_q == '0) ? PH_EOF0 : PH_DATA;
               end
               PH_DATA: begin
                  prev_zero_q <= ~cur_bit;
                  par_q       <= par_q ^ cur_bit;
                  bit_idx_q   <= idx_next;
                  if (want_par)
                     phase_q <= PH_PAR;
                  else if (last_bit)
                     phase_q <= PH_EOF0;
               end
               PH_PAR: begin
                  prev_zero_q <= ~par_q;
                  par_q       <= 1'b1;
                  phase_q     <= (bit_idx_q == total_q) ? PH_EOF0 : PH_DATA;
               end
               PH_EOF0: begin
                  prev_zero_q <= 1'b1;
                  phase_q     <= PH_EOFY;
               end
               PH_EOFY: begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign busy_o     = (phase_q != PH_IDLE);
   assign done_o     = done_q;
   assign byte_idx_o = bit_idx_q[CNT_W-1:3];

endmodule

// File: rtl/mm_pause_shaper.sv
module mm_pause_shaper
   import mm_enc_pkg::*;
#(
   parameter int CELL_CYCLES  = 128,
   parameter int PAUSE_CYCLES = 32,
   parameter bit PAUSE_HIGH   = 1'b1,
   localparam int TW = $clog2(CELL_CYCLES)
) (
   input  logic [TW-1:0] cnt_i,
   input  logic          busy_i,
   input  cell_sym_e     sym_i,
   output logic          pause_o
);

   localparam logic [TW-1:0] PW_C   = TW'(PAUSE_CYCLES);
   localparam logic [TW-1:0] HALF_C = TW'(CELL_CYCLES / 2);
   localparam logic [TW-1:0] XEND_C = TW'(CELL_CYCLES / 2 + PAUSE_CYCLES);

   logic active;

   always_comb begin
      active = 1'b0;
      if (busy_i) begin
         if (sym_i == SYM_Z)
            active = (cnt_i < PW_C);
         else if (sym_i == SYM_X)
            active = (cnt_i >= HALF_C) && (cnt_i < XEND_C);
      end
   end

   generate
      if (PAUSE_HIGH) begin : g_high
         assign pause_o = active;
      end else begin : g_low
         assign pause_o = ~active;
      end
   endgenerate

endmodule

// File: rtl/mm_frame_encoder.sv
module mm_frame_encoder
   import mm_enc_pkg::*;
#(
   parameter int CELL_CYCLES  = 128,
   parameter int PAUSE_CYCLES = 32,
   parameter int MAX_BITS     = 2325,
   parameter bit PAUSE_HIGH   = 1'b1,
   localparam int CNT_W = $clog2(MAX_BITS + 1),
   localparam int IDX_W = CNT_W - 3,
   localparam int TW    = $clog2(CELL_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       kind_i,
   input  logic [CNT_W-1:0] bit_count_i,
   input  logic [7:0]       src_byte_i,
   output logic [IDX_W-1:0] src_idx_o,
   output logic             pause_o,
   output logic             done_o
);

   generate
      if (CELL_CYCLES < 4 || (CELL_CYCLES % 2) != 0) begin : g_bad_cell
         $error("CELL_CYCLES must be even and at least 4");
      end
      if (PAUSE_CYCLES < 1 || PAUSE_CYCLES >= CELL_CYCLES / 2) begin : g_bad_pause
         $error("PAUSE_CYCLES must lie between 1 and half a cell");
      end
      if (MAX_BITS < 8) begin : g_bad_max
         $error("MAX_BITS must be at least 8");
      end
   endgenerate

   logic          busy;
   logic          cell_end;
   logic [TW-1:0] cell_cnt;
   cell_sym_e     sym;

   mm_cell_timer #(.CELL_CYCLES(CELL_CYCLES)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (busy),
      .cnt_o      (cell_cnt),
      .cell_end_o (cell_end)
   );

   mm_bit_sequencer #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .kind_i     (kind_i),
      .count_i    (bit_count_i),
      .byte_i     (src_byte_i),
      .cell_end_i (cell_end),
      .busy_o     (busy),
      .done_o     (done_o),
      .byte_idx_o (src_idx_o),
      .sym_o      (sym)
   );

   mm_pause_shaper #(
      .CELL_CYCLES  (CELL_CYCLES),
      .PAUSE_CYCLES (PAUSE_CYCLES),
      .PAUSE_HIGH   (PAUSE_HIGH)
   ) u_shape (
      .cnt_i   (cell_cnt),
      .busy_i  (busy),
      .sym_i   (sym),
      .pause_o (pause_o)
   );

endmodule

// File: rtl/mm_frame_encoder_chk.sv
module mm_frame_encoder_chk #(
   parameter int PAUSE_CYCLES = 32,
   parameter bit PAUSE_HIGH   = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy,
   input logic pause_o,
   input logic done_o
);

   logic        pz;
   logic [15:0] run_q;

   assign pz = PAUSE_HIGH ? pause_o : ~pause_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (pz)
         run_q <= run_q + 1'b1;
      else
         run_q <= '0;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pz);                                            // R10
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                       // R10
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_o);                                   // R10
   AST_SOF_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy) |=> pz);                                // R4
   AST_PAUSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      pz |-> (run_q < 16'(PAUSE_CYCLES)));                       // R2

endmodule

bind mm_frame_encoder mm_frame_encoder_chk #(
   .PAUSE_CYCLES (PAUSE_CYCLES),
   .PAUSE_HIGH   (PAUSE_HIGH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy    (busy),
   .pause_o (pause_o),
   .done_o  (done_o)
);

// File: tb/mm_frame_encoder_bench.sv
module mm_frame_encoder_bench;

   localparam int PW    = 32;
   localparam int CELL  = 128;
   localparam int HALF  = CELL / 2;
   localparam int CNT_W = 12;
   localparam int IDX_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       kind_r = 2'd0;
   logic [CNT_W-1:0] count_r = '0;
   logic [7:0]       mem [0:511];
   logic [IDX_W-1:0] src_idx;
   logic [7:0]       src_byte;
   logic             pause;
   logic             done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int exp_sym [0:1023];
   int exp_n;

   always #5 clk = ~clk;

   assign src_byte = mem[src_idx];

   mm_frame_encoder #(
      .CELL_CYCLES(CELL), .PAUSE_CYCLES(PW), .MAX_BITS(2325), .PAUSE_HIGH(1'b1)
   ) u_mm_frame_encoder (
      .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind_r),
      .bit_count_i(count_r), .src_byte_i(src_byte), .src_idx_o(src_idx),
      .pause_o(pause), .done_o(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Symbol codes: 0 = Y, 1 = X, 2 = Z
   function automatic int enc(input bit b, input bit pz);
      return b ? 1 : (pz ? 2 : 0);
   endfunction

   function automatic void push(input int s);
      exp_sym[exp_n] = s;
      exp_n++;
   endfunction

   // Expected symbol list built from R3, R5, R7, R8, R9, R12
   function automatic void build_expected(input int kind, input int cnt);
      int n;
      bit pz;
      bit par;
      bit b;
      exp_n = 0;
      n   = (kind == 0) ? 7 : cnt;
      pz  = 1'b1;
      par = 1'b1;
      push(2);
      for (int i = 0; i < n; i++) begin
         b = mem[i / 8][i % 8];
         push(enc(b, pz));
         pz  = !b;
         par = par ^ b;
         if (kind != 0 && ((i % 8) == 7 || (i == n - 1 && kind == 1))) begin
            push(enc(par, pz));
            pz  = !par;
            par = 1'b1;
         end
      end
      push(enc(1'b0, pz));
      push(0);
   endfunction

   task automatic run_frame(input int kind, input int cnt, input bit poke);
      bit s0, spw, sh;
      int got;
      build_expected(kind, cnt);
      @(negedge clk);
      kind_r  = 2'(kind);
      count_r = CNT_W'(cnt);
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      for (int k = 0; k < exp_n; k++) begin
         s0 = pause;
         repeat (PW) @(negedge clk);
         spw = pause;
         repeat (HALF - PW) @(negedge clk);
         sh = pause;
         if (k == exp_n - 1)
            check(done == 1'b0, "R10 done early", int'(done), 0);
         if (poke && k == 2) begin
            start   = 1'b1;   // R11: must be ignored mid-frame
            kind_r  = 2'd0;
            count_r = '0;
         end
         @(negedge clk);
         start = 1'b0;
         repeat (HALF - 1) @(negedge clk);
         if (spw)            got = 3;
         else if (s0 && !sh) got = 2;
         else if (!s0 && sh) got = 1;
         else if (!s0 && !sh) got = 0;
         else                got = 3;
         check(got == exp_sym[k], "R1 R2 R3 R6 cell symbol", got, exp_sym[k]);
      end
      check(done == 1'b1, "R10 done after last cell", int'(done), 1);
      @(negedge clk);
      check(done == 1'b0 && pause == 1'b0, "R10 idle after done",
            int'({done, pause}), 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 512; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      check(pause == 1'b0, "R10 reset pause", int'(pause), 0);
      check(done == 1'b0, "R10 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      mem[0] = 8'h2A; run_frame(0, 0, 1'b0);      // R7: Z ZXYXYXY ZY
      mem[0] = 8'h52; run_frame(0, 99, 1'b0);     // R7: count ignored, Z ZXYZXYX YY
      run_frame(1, 0, 1'b0);                      // R12 standard empty
      run_frame(2, 0, 1'b0);                      // R12 split empty
      mem[0] = 8'h00; mem[1] = 8'hFF;
      run_frame(1, 16, 1'b0);                     // R8 zero run, R5 after parity
      mem[0] = 8'hB5; mem[1] = 8'h03;
      run_frame(1, 12, 1'b0);                     // R8 partial byte parity
      run_frame(2, 12, 1'b0);                     // R9 no parity on cut byte
      run_frame(2, 16, 1'b0);                     // R9 parity on full byte
      run_frame(1, 10, 1'b1);                     // R11 start during frame
      for (int t = 0; t < 12; t++) begin          // R6 random bytes
         for (int i = 0; i < 4; i++) mem[i] = 8'($urandom());
         run_frame(int'($urandom_range(2, 0)), int'($urandom_range(24, 1)), 1'b0);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule